// File: doc/BRIEF.md
# Attenuator control word selector

This block produces the registered control word for a binary-weighted switched attenuator array. It has six bits. From the top bit down they weigh 16, 8, 4, 2, 1 and 0.5 dB, so the word covers 0 to 31.5 dB in half-decibel steps. The all-zero word is the reference-loss setting. A mode pin picks the source of the word. In parallel mode the word comes from six control pins, under a latch-enable pin. In serial mode it comes from a word that a separate serial shift-register block hands over, and that block applies its own latch rules.

In parallel mode the latch-enable pin gives two uses. Held high, it makes the word follow the control pins directly. Held low while the pins change, then pulsed high and brought low again, it captures a new setting. All pins arrive already synchronized to the system clock. The word changes only on rising clock edges.

Releasing reset sets a defined starting word. This happens once, on the first clock edge after reset is deasserted, using the pins sampled at that edge:
- Parallel mode with latch enable low: the word is one of four presets, picked by a two-pin boot selector.
- Serial mode: the word is captured from the parallel control pins.
- Parallel mode with latch enable high: ordinary direct operation applies.

Top module: `atten_word_sel`

## Requirements
- R1: While reset is asserted, the output word is all zeros (reference loss).
- R2: On the first clock edge after reset release, parallel mode (mode pin 0) with latch enable 0 loads a preset chosen by boot_sel_i. Bit 0 of boot_sel_i weighs 16 dB and bit 1 weighs 8 dB. Code 00 gives 6'b000000, 01 gives 6'b100000, 10 gives 6'b010000, and 11 gives 6'b111110 (every weight but 0.5 dB).
- R3: On the first clock edge after reset release, serial mode (mode pin 1) loads the word on the parallel control pins.
- R4: On the first clock edge after reset release, parallel mode with latch enable 1 loads the parallel control pins, and boot_sel_i has no effect.
- R5: After the first edge, in parallel mode with latch enable 1, the output equals the parallel pins sampled at the previous clock edge.
- R6: After the first edge, in parallel mode with latch enable 0, the output holds its value whatever the parallel pins or the serial word do. This includes the cycle after a switch from serial mode.
- R7: A latch-enable pulse (high, then low) in parallel mode leaves the output at the pin value present at the last edge where latch enable was high. That value then holds.
- R8: After the first edge, in serial mode, the output equals the serial word sampled at the previous clock edge.
- R9: The boot preset is applied only once. Later changes of boot_sel_i never change the output.
- R10: In serial mode the parallel pins and latch enable have no effect on the output after the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_serial_i | input | 1 | 0 selects parallel control, 1 selects serial control |
| latch_en_i | input | 1 | Latch enable: 1 transparent, 0 hold (parallel mode) |
| par_word_i | input | WORD_W (6) | Parallel control pins, MSB is 16 dB, LSB is 0.5 dB |
| boot_sel_i | input | 2 | Boot preset selector, bit 0 = 16 dB preset, bit 1 = 8 dB preset |
| ser_word_i | input | WORD_W (6) | Word presented by the serial shift-register block |
| atten_word_o | output | WORD_W (6) | Registered attenuator control word |

## Verification
The bench covers each of the four boot presets and checks the two bit positions against each other. A design that swapped the selector bits would load 8 dB where 16 dB is expected. A design that set the half-decibel bit on code 11 would show 31.5 dB instead of 31 dB. The bench then moves boot_sel_i and the parallel pins after the first edge, in hold and in serial mode, to catch a design that re-evaluates the boot rule or leaks the wrong source through. It also ends a latch-enable pulse on a changed pin value. A design that captured on the falling cycle would take the late value rather than the one present while latch enable was high.

// File: rtl/atten_sel_pkg.sv
package atten_sel_pkg;

   // Source of the next attenuator word
   typedef enum logic [1:0] {
      SRC_HOLD   = 2'd0,
      SRC_PAR    = 2'd1,
      SRC_SER    = 2'd2,
      SRC_PRESET = 2'd3
   } word_src_e;

   localparam int unsigned BOOT_SEL_W = 2;

endpackage

// File: rtl/atten_boot_preset.sv
module atten_boot_preset
   import atten_sel_pkg::*;
#(
   parameter int unsigned WORD_W = 6
) (
   input  logic [BOOT_SEL_W-1:0] sel_i,
   output logic [WORD_W-1:0]     preset_o
);

   localparam int unsigned TOP_BIT  = WORD_W - 1;
   localparam int unsigned NEXT_BIT = WORD_W - 2;

   if (WORD_W < 3) begin : g_bad_width
      $error("atten_boot_preset: WORD_W must be at least 3");
   end

   logic both_w;
   assign both_w = sel_i[0] & sel_i[1];

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      if (b == 0) begin : g_lsb
         assign preset_o[b] = 1'b0;
      end else if (b == TOP_BIT) begin : g_top
         assign preset_o[b] = sel_i[0] | both_w;
      end else if (b == NEXT_BIT) begin : g_next
         assign preset_o[b] = sel_i[1] | both_w;
      end else begin : g_mid
         assign preset_o[b] = both_w;
      end
   end

endmodule

// File: rtl/atten_boot_phase.sv
module atten_boot_phase (
   input  logic clk,
   input  logic rst_n,
   output logic boot_now_o
);

   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b1;
      else        pend_q <= 1'b0;
   end

   assign boot_now_o = pend_q;

   AST_BOOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      boot_now_o |=> !boot_now_o); // R9

endmodule

// File: rtl/atten_src_decode.sv
module atten_src_decode
   import atten_sel_pkg::*;
(
   input  logic      boot_now_i,
   input  logic      mode_serial_i,
   input  logic      latch_en_i,
   output word_src_e src_o
);

   always_comb begin
      if (boot_now_i) begin
         if (mode_serial_i)   src_o = SRC_PAR;
         else if (latch_en_i) src_o = SRC_PAR;
         else                 src_o = SRC_PRESET;
      end else begin
         if (mode_serial_i)   src_o = SRC_SER;
         else if (latch_en_i) src_o = SRC_PAR;
         else                 src_o = SRC_HOLD;
      end
   end

endmodule

// File: rtl/atten_word_sel.sv
module atten_word_sel
   import atten_sel_pkg::*;
#(
   parameter int unsigned WORD_W     = 6,
   parameter logic [5:0]  RESET_WORD = 6'd0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_serial_i,
   input  logic                  latch_en_i,
   input  logic [WORD_W-1:0]     par_word_i,
   input  logic [BOOT_SEL_W-1:0] boot_sel_i,
   input  logic [WORD_W-1:0]     ser_word_i,
   output logic [WORD_W-1:0]     atten_word_o
);

   localparam int unsigned RST_W = (WORD_W < 6) ? WORD_W : 6;

   if (WORD_W < 3) begin : g_bad_width
      $error("atten_word_sel: WORD_W must be at least 3");
   end

   logic              boot_now_w;
   word_src_e         src_w;
   logic [WORD_W-1:0] preset_w;
   logic [WORD_W-1:0] next_w;
   logic [WORD_W-1:0] word_q;
   logic [WORD_W-1:0] rst_word_w;

   assign rst_word_w = WORD_W'(RESET_WORD[RST_W-1:0]);

   atten_boot_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .boot_now_o (boot_now_w)
   );

   atten_src_decode u_decode (
      .boot_now_i    (boot_now_w),
      .mode_serial_i (mode_serial_i),
      .latch_en_i    (latch_en_i),
      .src_o         (src_w)
   );

   atten_boot_preset #(.WORD_W(WORD_W)) u_preset (
      .sel_i    (boot_sel_i),
      .preset_o (preset_w)
   );

   always_comb begin
      unique case (src_w)
         SRC_PAR:    next_w = par_word_i;
         SRC_SER:    next_w = ser_word_i;
         SRC_PRESET: next_w = preset_w;
         default:    next_w = word_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= rst_word_w;
      else        word_q <= next_w;
   end

   assign atten_word_o = word_q;

   AST_BOOT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      boot_now_w && !mode_serial_i && !latch_en_i |=> atten_word_o == $past(preset_w)); // R2
   AST_BOOT_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
      boot_now_w && mode_serial_i |=> atten_word_o == $past(par_word_i)); // R3
   AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_serial_i && latch_en_i |=> atten_word_o == $past(par_word_i)); // R5
   AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_now_w && !mode_serial_i && !latch_en_i |=> $stable(atten_word_o)); // R6
   AST_SERIAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_now_w && mode_serial_i |=> atten_word_o == $past(ser_word_i)); // R8

endmodule

// File: tb/atten_word_sel_test.sv
module atten_word_sel_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_serial = 1'b0;
   logic       latch_en = 1'b0;
   logic [5:0] par_word = '0;
   logic [1:0] boot_sel = '0;
   logic [5:0] ser_word = '0;
   logic [5:0] atten_word;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   atten_word_sel uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_serial_i (mode_serial),
      .latch_en_i    (latch_en),
      .par_word_i    (par_word),
      .boot_sel_i    (boot_sel),
      .ser_word_i    (ser_word),
      .atten_word_o  (atten_word)
   );

   task automatic check(input string req, input logic [5:0] exp);
      n_checks++;
      if (atten_word !== exp) begin
         n_fails++;
         $display("FAIL %s: atten_word=%b expected=%b", req, atten_word, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [5:0] preset_of(input logic [1:0] s);
      case (s)
         2'b00:   return 6'b000000;
         2'b01:   return 6'b100000;
         2'b10:   return 6'b010000;
         default: return 6'b111110;
      endcase
   endfunction

   // Reset with given pins, check R1, release and take the boot edge
   task automatic boot(input logic m, input logic le, input logic [5:0] p,
                       input logic [1:0] s, input logic [5:0] sw);
      @(negedge clk);
      rst_n = 1'b0;
      mode_serial = m; latch_en = le; par_word = p; boot_sel = s; ser_word = sw;
      tick(); tick();
      check("R1 reset word", 6'b000000);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_presets();
      for (int s = 0; s < 4; s++) begin
         boot(1'b0, 1'b0, 6'b010101, 2'(s), 6'b101010);
         check("R2 boot preset", preset_of(2'(s)));
         par_word = 6'b001100; ser_word = 6'b110011;
         tick();
         check("R6 hold after preset", preset_of(2'(s)));
      end
   endtask

   task automatic t_boot_serial();
      boot(1'b1, 1'b0, 6'b101011, 2'b11, 6'b010001);
      check("R3 serial boot captures pins", 6'b101011);
      tick();
      check("R8 serial follows word", 6'b010001);
      ser_word = 6'b111111;
      tick();
      check("R8 serial follows new word", 6'b111111);
      par_word = 6'b000011; latch_en = 1'b1;
      tick();
      check("R10 pins ignored in serial", 6'b111111);
      latch_en = 1'b0; par_word = 6'b100100;
      tick();
      check("R10 latch enable ignored in serial", 6'b111111);
      ser_word = 6'b000110;
      tick();
      mode_serial = 1'b0; ser_word = 6'b011011; par_word = 6'b110000;
      tick();
      check("R6 hold after switch from serial", 6'b000110);
   endtask

   task automatic t_boot_direct();
      boot(1'b0, 1'b1, 6'b000101, 2'b11, 6'b000000);
      check("R4 direct boot ignores selector", 6'b000101);
      for (int i = 0; i < 4; i++) begin
         par_word = 6'(i * 13 + 7);
         tick();
         check("R5 direct follow", 6'(i * 13 + 7));
      end
   endtask

   task automatic t_latch_pulse();
      boot(1'b0, 1'b0, 6'b000000, 2'b10, 6'b000000);
      check("R2 boot preset 8 dB", 6'b010000);
      par_word = 6'b001010;
      tick();
      check("R6 hold while loading", 6'b010000);
      latch_en = 1'b1; par_word = 6'b110011;
      tick();
      check("R7 pulse high transparent", 6'b110011);
      latch_en = 1'b0; par_word = 6'b001100;
      tick();
      check("R7 pulse low keeps high value", 6'b110011);
      tick();
      check("R7 held after pulse", 6'b110011);
   endtask

   task automatic t_boot_once();
      boot(1'b0, 1'b0, 6'b000000, 2'b01, 6'b000000);
      check("R2 boot preset 16 dB", 6'b100000);
      for (int s = 0; s < 4; s++) begin
         boot_sel = 2'(s);
         tick();
         check("R9 selector ignored after boot", 6'b100000);
      end
   endtask

   initial begin
      tick();
      check("R1 initial reset", 6'b000000);
      t_presets();
      t_boot_serial();
      t_boot_direct();
      t_latch_pulse();
      t_boot_once();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule